// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This block moderates the completion interrupts of one DMA channel. It keeps a packet counter that is loaded from a programmable threshold and counts down on every finished packet. When the count runs out it issues a one-cycle set-pulse for the completion interrupt flag and starts over. Alongside the counter runs a one-shot delay timer. Each finished packet restarts it, and it counts down on an external tick. If the timer runs out before another packet finishes, it issues a set-pulse for the delay interrupt flag and rearms the packet counter. This means a trickle of traffic still produces an interrupt within a bounded time.

The threshold and delay fields come live from the channel's control register, which is stored outside this block. A strobe marks each write to that register. The flag registers and their clearing also sit outside. This block only issues the set-pulses. The live counter and timer values are brought out so that the status register can return them on a read. All pins are plain control and status signals with no back-pressure. Every input is a single-cycle level or pulse, and it is sampled on every rising clock edge.

Top module: `irq_coalesce`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the counter reads 1, the timer reads 0 and neither set-pulse is high.
- R2: A control-write strobe reloads the counter from the threshold field. It has priority over a completion in the same cycle: the counter does not decrement and no completion pulse is issued.
- R3: A completion with no control write, seen while the counter is above 1, lowers the counter by exactly one.
- R4: A completion with no control write, seen while the counter is 1, raises `cmpl_irq_set` for exactly one cycle on the next cycle and reloads the counter from the threshold field.
- R5: A threshold field of zero acts as a threshold of one. The counter never reads zero, and every completion then issues a completion pulse.
- R6: A completion seen while the delay field is nonzero loads the timer with the delay value, even if the timer is already running. A completion seen while the delay field is zero leaves the timer unchanged.
- R7: A tick decrements a nonzero timer by one. A tick seen while the timer is zero leaves it at zero and issues nothing.
- R8: A tick seen while the timer is 1 is an expiry. It raises `dly_irq_set` for exactly one cycle on the next cycle, leaves the timer at 0 and reloads the counter from the threshold field.
- R9: When a completion and an expiry fall in the same cycle, the counter follows the completion rule. Each pulse whose condition holds is issued, so both may appear together.
- R10: `cmpl_count` and `dly_count` show the low bits of the counter and of the timer, and they change on the same edge as the state they show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_thresh | input | CNT_W | Completion threshold field (control bits 23:16) |
| cfg_delay | input | DLY_W | Delay timer reload field (control bits 31:24) |
| cfg_wr | input | 1 | Strobe, one cycle per control-register write |
| pkt_done | input | 1 | Pulse, one packet completed |
| tmr_tick | input | 1 | Timer tick from an external prescaler |
| cmpl_irq_set | output | 1 | Set-pulse for the completion flag (status bit 12) |
| dly_irq_set | output | 1 | Set-pulse for the delay flag (status bit 13) |
| cmpl_count | output | RB_W | Counter readback (status bits 23:16) |
| dly_count | output | RB_W | Timer readback (status bits 31:24) |

## Verification
The bench builds the unit with its default parameters: 8-bit threshold, delay and readback fields, and a counter that resets to 1. With these values the full field range is within reach, up to a threshold and delay of 255, and so is the zero threshold, as well as a delay of 1 that makes an expiry follow directly from one tick. Small threshold and delay values are used so that same-cycle collisions are reached within a few cycles. These collisions are a completion with an expiry, a completion with a control write, and a restart with a tick. Both pulses firing together is also reached this way.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
  // positions of the two interrupt events inside the pulse vector
  localparam int unsigned EV_CMPL = 0;
  localparam int unsigned EV_DLY  = 1;
  localparam int unsigned EV_NUM  = 2;

  typedef logic [EV_NUM-1:0] ev_vec_t;
endpackage

// File: rtl/ic_pkt_counter.sv
module ic_pkt_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned RST_CNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh,
  input  logic             reload_wr,
  input  logic             done,
  input  logic             tmr_expire,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] eff_thresh;
  logic [CNT_W-1:0] cnt_q;

  // zero threshold is promoted to one so the count can never wrap
  assign eff_thresh = (thresh == '0) ? ONE : thresh;
  assign hit        = done && !reload_wr && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(RST_CNT);
    end else if (reload_wr) begin
      cnt_q <= eff_thresh;
    end else if (done) begin
      cnt_q <= hit ? eff_thresh : cnt_q - ONE;
    end else if (tmr_expire) begin
      cnt_q <= eff_thresh;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ic_delay_timer.sv
module ic_delay_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay,
  input  logic             restart,
  input  logic             tick,
  output logic [DLY_W-1:0] tmr,
  output logic             expire
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] tmr_q;
  logic             armed;

  assign armed  = (tmr_q != '0);
  assign expire = tick && (tmr_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (restart) begin
      tmr_q <= delay;
    end else if (tick && armed) begin
      tmr_q <= tmr_q - ONE;
    end
  end

  assign tmr = tmr_q;
endmodule

// File: rtl/ic_set_pulse.sv
module ic_set_pulse
  import irq_coalesce_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t ev,
  output ev_vec_t pulse
);
  for (genvar i = 0; i < EV_NUM; i++) begin : g_ev
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ev[i];
    end
    assign pulse[i] = q;
  end
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import irq_coalesce_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned RB_W    = 8,
  parameter int unsigned RST_CNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cfg_wr,
  input  logic             pkt_done,
  input  logic             tmr_tick,
  output logic             cmpl_irq_set,
  output logic             dly_irq_set,
  output logic [RB_W-1:0]  cmpl_count,
  output logic [RB_W-1:0]  dly_count
);
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] tmr_q;
  logic             cnt_hit;
  logic             tmr_exp;
  logic             tmr_restart;
  ev_vec_t          ev;
  ev_vec_t          pulse;

  assign tmr_restart = pkt_done && (cfg_delay != '0);

  ic_pkt_counter #(.CNT_W(CNT_W), .RST_CNT(RST_CNT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .thresh     (cfg_thresh),
    .reload_wr  (cfg_wr),
    .done       (pkt_done),
    .tmr_expire (tmr_exp),
    .cnt        (cnt_q),
    .hit        (cnt_hit)
  );

  ic_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .delay   (cfg_delay),
    .restart (tmr_restart),
    .tick    (tmr_tick),
    .tmr     (tmr_q),
    .expire  (tmr_exp)
  );

  always_comb begin
    ev          = '0;
    ev[EV_CMPL] = cnt_hit;
    ev[EV_DLY]  = tmr_exp;
  end

  ic_set_pulse u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev),
    .pulse (pulse)
  );

  assign cmpl_irq_set = pulse[EV_CMPL];
  assign dly_irq_set  = pulse[EV_DLY];

  // readback keeps the low bits; narrower state is zero-extended
  if (RB_W <= CNT_W) begin : g_rb_cnt_trunc
    assign cmpl_count = cnt_q[RB_W-1:0];
  end else begin : g_rb_cnt_ext
    assign cmpl_count = {{(RB_W-CNT_W){1'b0}}, cnt_q};
  end

  if (RB_W <= DLY_W) begin : g_rb_tmr_trunc
    assign dly_count = tmr_q[RB_W-1:0];
  end else begin : g_rb_tmr_ext
    assign dly_count = {{(RB_W-DLY_W){1'b0}}, tmr_q};
  end
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cfg_thresh,
  input logic [DLY_W-1:0] cfg_delay,
  input logic             cfg_wr,
  input logic             pkt_done,
  input logic             tmr_tick,
  input logic             cmpl_irq_set,
  input logic             dly_irq_set,
  input logic [CNT_W-1:0] cnt_q,
  input logic [DLY_W-1:0] tmr_q
);
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);
  localparam logic [DLY_W-1:0] T1 = DLY_W'(1);

  // R2
  cfg_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cnt_q == (($past(cfg_thresh) == '0) ? C1 : $past(cfg_thresh)));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !cfg_wr && cnt_q > C1) |=> cnt_q == CNT_W'($past(cnt_q) - C1));

  // R4
  cmpl_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !cfg_wr && cnt_q == C1) |=> cmpl_irq_set);

  // R4
  cmpl_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmpl_irq_set) |-> ($past(pkt_done) && !$past(cfg_wr) && $past(cnt_q) == C1));

  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

  // R6
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && cfg_delay != '0) |=> tmr_q == $past(cfg_delay));

  // R7
  tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_tick && tmr_q > T1 && !(pkt_done && cfg_delay != '0))
      |=> tmr_q == DLY_W'($past(tmr_q) - T1));

  // R8
  dly_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dly_irq_set |-> ($past(tmr_tick) && $past(tmr_q) == T1));

  // R9
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !cfg_wr && tmr_tick && tmr_q == T1 && cnt_q == C1)
      |=> (cmpl_irq_set && dly_irq_set));
endmodule

bind irq_coalesce irq_coalesce_chk #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_thresh   (cfg_thresh),
  .cfg_delay    (cfg_delay),
  .cfg_wr       (cfg_wr),
  .pkt_done     (pkt_done),
  .tmr_tick     (tmr_tick),
  .cmpl_irq_set (cmpl_irq_set),
  .dly_irq_set  (dly_irq_set),
  .cnt_q        (cnt_q),
  .tmr_q        (tmr_q)
);

// File: tb/tb_irq_coalesce.sv
`timescale 1ns/1ps
module tb_irq_coalesce;
  localparam int NV = 30;

  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [7:0] thr;
    logic [7:0] dly;
    logic       done;
    logic       tick;
    logic [7:0] ecnt;
    logic [7:0] etmr;
    logic       ecs;
    logic       eds;
  } vec_t;

  // req, wr, thr, dly, done, tick, exp cnt, exp tmr, exp cmpl, exp dly
  localparam vec_t VECS [0:NV-1] = '{
    '{4'd2,  1'b1, 8'd3,   8'd4,   1'b0, 1'b0, 8'd3,   8'd0,   1'b0, 1'b0}, // R2 write loads 3
    '{4'd3,  1'b0, 8'd3,   8'd4,   1'b1, 1'b0, 8'd2,   8'd4,   1'b0, 1'b0}, // R3 R6
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd2,   8'd3,   1'b0, 1'b0}, // R7
    '{4'd6,  1'b0, 8'd3,   8'd4,   1'b1, 1'b0, 8'd1,   8'd4,   1'b0, 1'b0}, // R6 restart while running
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd1,   8'd3,   1'b0, 1'b0}, // R7
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd1,   8'd2,   1'b0, 1'b0}, // R7
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd1,   8'd1,   1'b0, 1'b0}, // R7
    '{4'd8,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd3,   8'd0,   1'b0, 1'b1}, // R8 expiry reloads
    '{4'd8,  1'b0, 8'd3,   8'd4,   1'b0, 1'b0, 8'd3,   8'd0,   1'b0, 1'b0}, // R8 single-cycle pulse
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd3,   8'd0,   1'b0, 1'b0}, // R7 tick at zero
    '{4'd3,  1'b0, 8'd3,   8'd4,   1'b1, 1'b0, 8'd2,   8'd4,   1'b0, 1'b0}, // R3
    '{4'd3,  1'b0, 8'd3,   8'd4,   1'b1, 1'b0, 8'd1,   8'd4,   1'b0, 1'b0}, // R3
    '{4'd4,  1'b0, 8'd3,   8'd4,   1'b1, 1'b0, 8'd3,   8'd4,   1'b1, 1'b0}, // R4 count runs out
    '{4'd4,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd3,   8'd3,   1'b0, 1'b0}, // R4 single-cycle pulse
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd3,   8'd2,   1'b0, 1'b0}, // R7
    '{4'd7,  1'b0, 8'd3,   8'd4,   1'b0, 1'b1, 8'd3,   8'd1,   1'b0, 1'b0}, // R7
    '{4'd9,  1'b0, 8'd3,   8'd4,   1'b1, 1'b1, 8'd2,   8'd4,   1'b0, 1'b1}, // R9 completion wins counter
    '{4'd5,  1'b1, 8'd0,   8'd0,   1'b0, 1'b0, 8'd1,   8'd4,   1'b0, 1'b0}, // R5 zero threshold
    '{4'd5,  1'b0, 8'd0,   8'd0,   1'b1, 1'b0, 8'd1,   8'd4,   1'b1, 1'b0}, // R5 R6 zero delay
    '{4'd5,  1'b0, 8'd0,   8'd0,   1'b1, 1'b0, 8'd1,   8'd4,   1'b1, 1'b0}, // R5
    '{4'd2,  1'b1, 8'd2,   8'd2,   1'b1, 1'b0, 8'd2,   8'd2,   1'b0, 1'b0}, // R2 write beats completion
    '{4'd7,  1'b0, 8'd2,   8'd2,   1'b0, 1'b1, 8'd2,   8'd1,   1'b0, 1'b0}, // R7
    '{4'd6,  1'b0, 8'd2,   8'd2,   1'b1, 1'b0, 8'd1,   8'd2,   1'b0, 1'b0}, // R6
    '{4'd7,  1'b0, 8'd2,   8'd2,   1'b0, 1'b1, 8'd1,   8'd1,   1'b0, 1'b0}, // R7
    '{4'd9,  1'b0, 8'd2,   8'd2,   1'b1, 1'b1, 8'd2,   8'd2,   1'b1, 1'b1}, // R9 both pulses
    '{4'd7,  1'b0, 8'd2,   8'd2,   1'b0, 1'b1, 8'd2,   8'd1,   1'b0, 1'b0}, // R7
    '{4'd8,  1'b0, 8'd2,   8'd2,   1'b0, 1'b1, 8'd2,   8'd0,   1'b0, 1'b1}, // R8
    '{4'd10, 1'b1, 8'd255, 8'd255, 1'b0, 1'b0, 8'd255, 8'd0,   1'b0, 1'b0}, // R10 full range
    '{4'd10, 1'b0, 8'd255, 8'd255, 1'b1, 1'b0, 8'd254, 8'd255, 1'b0, 1'b0}, // R10
    '{4'd10, 1'b0, 8'd255, 8'd255, 1'b0, 1'b1, 8'd254, 8'd254, 1'b0, 1'b0}  // R10
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_thresh = '0;
  logic [7:0] cfg_delay = '0;
  logic       cfg_wr = 1'b0;
  logic       pkt_done = 1'b0;
  logic       tmr_tick = 1'b0;
  logic       cmpl_irq_set;
  logic       dly_irq_set;
  logic [7:0] cmpl_count;
  logic [7:0] dly_count;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  irq_coalesce dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_thresh   (cfg_thresh),
    .cfg_delay    (cfg_delay),
    .cfg_wr       (cfg_wr),
    .pkt_done     (pkt_done),
    .tmr_tick     (tmr_tick),
    .cmpl_irq_set (cmpl_irq_set),
    .dly_irq_set  (dly_irq_set),
    .cmpl_count   (cmpl_count),
    .dly_count    (dly_count)
  );

  task automatic check(input string req, input logic [7:0] ecnt, input logic [7:0] etmr,
                       input logic ecs, input logic eds);
    n_chk++;
    if (cmpl_count !== ecnt || dly_count !== etmr ||
        cmpl_irq_set !== ecs || dly_irq_set !== eds) begin
      n_err++;
      $display("FAIL %s: got cnt=%0d tmr=%0d cmpl=%b dly=%b, expected cnt=%0d tmr=%0d cmpl=%b dly=%b",
               req, cmpl_count, dly_count, cmpl_irq_set, dly_irq_set, ecnt, etmr, ecs, eds);
    end
  endtask

  task automatic idle_inputs();
    cfg_wr = 1'b0; pkt_done = 1'b0; tmr_tick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 8'd1, 8'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 8'd1, 8'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cfg_wr     = VECS[i].wr;
      cfg_thresh = VECS[i].thr;
      cfg_delay  = VECS[i].dly;
      pkt_done   = VECS[i].done;
      tmr_tick   = VECS[i].tick;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].ecnt, VECS[i].etmr, VECS[i].ecs, VECS[i].eds);
    end
    idle_inputs();
    @(negedge clk);
    check("R10 hold", 8'd254, 8'd254, 1'b0, 1'b0);

    // R1: reset in the middle of a running timer
    rst_n = 1'b0;
    #1;
    check("R1 async reset mid-run", 8'd1, 8'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 released", 8'd1, 8'd0, 1'b0, 1'b0);

    // R4 and R8 with delay 1: one tick expires right away
    cfg_thresh = 8'd1; cfg_delay = 8'd1; cfg_wr = 1'b1;
    @(negedge clk); idle_inputs();
    check("R2 load threshold 1", 8'd1, 8'd0, 1'b0, 1'b0);
    pkt_done = 1'b1;
    @(negedge clk); idle_inputs();
    check("R4 threshold 1 pulses each time", 8'd1, 8'd1, 1'b1, 1'b0);
    tmr_tick = 1'b1;
    @(negedge clk); idle_inputs();
    check("R8 delay 1 expires on first tick", 8'd1, 8'd0, 1'b0, 1'b1);
    // R6: restart and tick in the same cycle, restart wins
    pkt_done = 1'b1; tmr_tick = 1'b1; cfg_delay = 8'd5;
    @(negedge clk); idle_inputs();
    check("R6 restart beats tick", 8'd1, 8'd5, 1'b1, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule